// File: doc/BRIEF.md
# BCD Calendar Clock Core

A real-time-clock counting core that advances on a one-cycle tick input, normally one pulse per second derived elsewhere from a slow oscillator. It keeps seconds, minutes, hours, day of month, month, two-digit year and weekday, each as a packed BCD byte (two decimal digits, high digit in bits 7:4). A byte-wide register port with address, write data, write strobe and combinational read data gives software access to the fields, a control register and a status register.

Counting happens only while the run bit of the control register is set. While it is clear, the time registers are frozen and can be loaded one byte at a time. A snapshot bit in the control register copies all seven live fields into a shadow bank in a single clock edge. A read-select bit then steers reads of the time fields to that bank, so software reading byte by byte always gets one consistent set of values. Four registered pulse outputs mark each counted second and each minute, hour and day rollover for an external status or interrupt block.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control register reads 0x00, which means stopped with live reads, and all tick outputs are low.
- R2: Byte addresses 0 to 6 hold seconds, minutes, hours, day of month, month, year and weekday, in that order. Address 8 is control: bit 0 is run, bit 6 is snapshot and bit 7 is read-select. Address 9 is status, with the run state in bit 1.
- R3: While run is 1, each cycle with tick_i high advances seconds by one. While run is 0, no field changes on tick_i.
- R4: Seconds and minutes roll from 0x59 to 0x00 and hours from 0x23 to 0x00, each carrying into the next field. The month rolls from 0x12 to 0x01 and carries into the year. The year rolls from 0x99 to 0x00.
- R5: The day of month rolls to 0x01 after the last day of the current month. That last day is 0x31, or 0x30 for April, June, September and November. For February it is 0x29 when the year value is divisible by 4 (00 included), and 0x28 otherwise.
- R6: The weekday counts 0x00 to 0x06 and advances at every midnight rollover, going from 0x06 back to 0x00.
- R7: A write to a time register while run is 0 loads that byte on the next edge. The same write while run is 1 has no effect.
- R8: A control write with bit 6 set copies all seven live fields, as they stood before that edge, into the shadow bank. Without such a write the shadow bank holds its contents.
- R9: With read-select 1, addresses 0 to 6 return the shadow bank. With read-select 0 they return the live fields. Bit 6 of control always reads 0.
- R10: Status reads {6'b0, run, 1'b0}. Writes to status have no effect.
- R11: tick_sec_o, tick_min_o, tick_hour_o and tick_day_o are high for exactly the cycle after an edge on which a second was counted, the seconds wrapped, the minutes wrapped and the hours wrapped, respectively.
- R12: rdata_o follows addr_i in the same cycle. Addresses 7 and 10 and up read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable, one per second |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i |
| tick_sec_o | output | 1 | Pulse per counted second |
| tick_min_o | output | 1 | Pulse on minute rollover |
| tick_hour_o | output | 1 | Pulse on hour rollover |
| tick_day_o | output | 1 | Pulse on day rollover |

## Verification
Read data is combinational, so a register write or a counted tick shows on rdata_o in the cycle right after the edge that took it, and the tick pulses appear in that same cycle. The bench drives inputs just after each rising edge. It updates a behavioural model of integer fields on the edge, then compares rdata_o and all four tick outputs with the model at every falling edge, so every result is checked exactly one edge after its cause. The address is swept while the clock runs, so every field is checked against the model many times across the stimulus.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int BYTE_W     = 8;

  typedef logic [BYTE_W-1:0] bcd_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 6;
  localparam int CTRL_SEL  = 7;
  localparam int STAT_RUN  = 1;

  // day and month start at 1, others at 0
  function automatic bcd_t field_base(int idx);
    return (idx == F_DAY || idx == F_MON) ? bcd_t'(8'h01) : bcd_t'(8'h00);
  endfunction

  function automatic bcd_t bcd_inc(bcd_t v);
    bcd_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr
  import rtc_cal_pkg::*;
#(
  parameter bcd_t MIN_VAL = 8'h00,
  parameter bcd_t RST_VAL = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  logic inc_i,
  input  bcd_t max_i,
  output bcd_t val_o,
  output logic at_max_o
);
  bcd_t val_q;

  // >= keeps an out-of-range loaded value from running away
  assign at_max_o = (val_q >= max_i);
  assign val_o    = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= RST_VAL;
    else if (ld_i)     val_q <= ld_val_i;
    else if (inc_i)    val_q <= at_max_o ? MIN_VAL : bcd_inc(val_q);
  end

  p_wrap_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && at_max_o) |=> (val_q == MIN_VAL));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(val_q));
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  bcd_t month_i,
  input  bcd_t year_i,
  output bcd_t last_day_o
);
  logic [BYTE_W-1:0] year_bin;
  logic              leap;

  assign year_bin = (BYTE_W'(year_i[7:4]) * BYTE_W'(10)) + BYTE_W'(year_i[3:0]);
  assign leap     = ((year_bin % BYTE_W'(4)) == '0);

  always_comb begin
    case (month_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_cal_pkg::*;
#(
  parameter int NUM = NUM_FIELDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               snap_i,
  input  bcd_t [NUM-1:0]     live_i,
  output bcd_t [NUM-1:0]     shadow_o
);
  bcd_t [NUM-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM; k++) shadow_q[k] <= field_base(k);
    end else if (snap_i) begin
      shadow_q <= live_i;
    end
  end

  assign shadow_o = shadow_q;

  p_snap_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (shadow_q == $past(live_i)));

  p_snap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(shadow_q));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 8,
  parameter int STAT_ADDR = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic              tick_sec_o,
  output logic              tick_min_o,
  output logic              tick_hour_o,
  output logic              tick_day_o
);
  localparam int FIDX_W = $clog2(NUM_FIELDS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] NF_A   = ADDR_W'(NUM_FIELDS);

  logic run_q, sel_q;
  logic ctrl_wr, snap;
  logic step;
  bcd_t last_day;

  bcd_t [NUM_FIELDS-1:0] live, shadow, maxv;
  logic [NUM_FIELDS-1:0] ld, inc, at_max;

  logic tk_sec_q, tk_min_q, tk_hour_q, tk_day_q;

  assign ctrl_wr = we_i && (addr_i == CTRL_A);
  assign snap    = ctrl_wr && wdata_i[CTRL_SNAP];
  assign step    = tick_i && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (ctrl_wr) begin
      run_q <= wdata_i[CTRL_RUN];
      sel_q <= wdata_i[CTRL_SEL];
    end
  end

  rtc_month_len u_mlen (
    .month_i   (live[F_MON]),
    .year_i    (live[F_YEAR]),
    .last_day_o(last_day)
  );

  always_comb begin
    maxv[F_SEC]  = 8'h59;
    maxv[F_MIN]  = 8'h59;
    maxv[F_HOUR] = 8'h23;
    maxv[F_DAY]  = last_day;
    maxv[F_MON]  = 8'h12;
    maxv[F_YEAR] = 8'h99;
    maxv[F_WDAY] = 8'h06;
  end

  // carry chain as explicit prefix ANDs, weekday rides the midnight carry
  always_comb begin
    logic c;
    c = step;
    inc[F_SEC]  = c;
    c = c && at_max[F_SEC];
    inc[F_MIN]  = c;
    c = c && at_max[F_MIN];
    inc[F_HOUR] = c;
    c = c && at_max[F_HOUR];
    inc[F_DAY]  = c;
    inc[F_WDAY] = c;
    c = c && at_max[F_DAY];
    inc[F_MON]  = c;
    c = c && at_max[F_MON];
    inc[F_YEAR] = c;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign ld[g] = we_i && !run_q && (addr_i == ADDR_W'(g));
    rtc_field_ctr #(
      .MIN_VAL(field_base(g)),
      .RST_VAL(field_base(g))
    ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (ld[g]),
      .ld_val_i(wdata_i),
      .inc_i   (inc[g]),
      .max_i   (maxv[g]),
      .val_o   (live[g]),
      .at_max_o(at_max[g])
    );
  end

  rtc_shadow #(.NUM(NUM_FIELDS)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .snap_i  (snap),
    .live_i  (live),
    .shadow_o(shadow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_sec_q  <= 1'b0;
      tk_min_q  <= 1'b0;
      tk_hour_q <= 1'b0;
      tk_day_q  <= 1'b0;
    end else begin
      tk_sec_q  <= inc[F_SEC];
      tk_min_q  <= inc[F_MIN];
      tk_hour_q <= inc[F_HOUR];
      tk_day_q  <= inc[F_DAY];
    end
  end

  assign tick_sec_o  = tk_sec_q;
  assign tick_min_o  = tk_min_q;
  assign tick_hour_o = tk_hour_q;
  assign tick_day_o  = tk_day_q;

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i < NF_A) begin
      rdata_o = sel_q ? shadow[addr_i[FIDX_W-1:0]] : live[addr_i[FIDX_W-1:0]];
    end else if (addr_i == CTRL_A) begin
      rdata_o = 8'h00;
      rdata_o[CTRL_RUN] = run_q;
      rdata_o[CTRL_SEL] = sel_q;
    end else if (addr_i == STAT_A) begin
      rdata_o = 8'h00;
      rdata_o[STAT_RUN] = run_q;
    end
  end

  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !we_i) |=> $stable(live));

  p_run_no_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick_i) |=> $stable(live));

  p_nest_day_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_day_o |-> (tick_hour_o && tick_min_o && tick_sec_o));

  p_nest_hour_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_hour_o |-> (tick_min_o && tick_sec_o));

  p_min_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_min_o |=> !tick_min_o);

  p_wday_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live[F_WDAY] <= 8'h06) |=> (live[F_WDAY] <= 8'h06));
endmodule

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       t_sec, t_min, t_hour, t_day;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int  m [7];
  int  sh [7];
  bit  run, sel;
  bit  e_s, e_m, e_h, e_d;

  rtc_bcd_calendar dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata),
    .tick_sec_o(t_sec), .tick_min_o(t_min), .tick_hour_o(t_hour), .tick_day_o(t_day)
  );

  always #5 clk = ~clk;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    if (a < 7) return 8'(to_bcd(sel ? sh[a] : m[a]));
    if (a == 8) return {sel, 6'b0, run};
    if (a == 9) return {6'b0, run, 1'b0};
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = '{0, 0, 0, 1, 1, 0, 0};
      sh = '{0, 0, 0, 1, 1, 0, 0};
      run = 0; sel = 0;
      e_s = 0; e_m = 0; e_h = 0; e_d = 0;
    end else begin
      e_s = 0; e_m = 0; e_h = 0; e_d = 0;
      if (we && addr == 8 && wdata[6]) sh = m;
      if (we && addr < 7 && !run) m[addr] = from_bcd(wdata);
      if (tick && run) begin
        e_s = 1;
        if (m[0] == 59) begin
          m[0] = 0; e_m = 1;
          if (m[1] == 59) begin
            m[1] = 0; e_h = 1;
            if (m[2] == 23) begin
              m[2] = 0; e_d = 1;
              m[6] = (m[6] == 6) ? 0 : m[6] + 1;
              if (m[3] >= days_in(m[4], m[5])) begin
                m[3] = 1;
                if (m[4] == 12) begin
                  m[4] = 1;
                  m[5] = (m[5] == 99) ? 0 : m[5] + 1;
                end else m[4] = m[4] + 1;
              end else m[3] = m[3] + 1;
            end else m[2] = m[2] + 1;
          end else m[1] = m[1] + 1;
        end else m[0] = m[0] + 1;
      end
      if (we && addr == 8) begin
        run = wdata[0];
        sel = wdata[7];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] ex;
      ex = exp_read(int'(addr));
      vectors++;
      if (rdata !== ex) begin
        fails++;
        $display("FAIL %s addr=%0d rdata actual=%02h expected=%02h", cur_req, addr, rdata, ex);
      end
      if ({t_sec, t_min, t_hour, t_day} !== {e_s, e_m, e_h, e_d}) begin
        fails++;
        $display("FAIL R11 ticks s/m/h/d actual=%b expected=%b",
                 {t_sec, t_min, t_hour, t_day}, {e_s, e_m, e_h, e_d});
      end
    end
  end

  task automatic drive(bit w, int a, int d, bit tk);
    @(posedge clk); #2;
    we = w; addr = 5'(a); wdata = 8'(d); tick = tk;
  endtask

  task automatic wr(int a, int d); drive(1, a, d, 0); endtask
  task automatic rd(int a);        drive(0, a, 0, 0); endtask

  task automatic scan();
    for (int a = 0; a < 12; a++) rd(a);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      drive(0, i % 10, 0, 1);
      for (int j = 0; j < gap; j++) drive(0, (i + j) % 10, 0, 0);
    end
  endtask

  task automatic set_time(int s, int mi, int h, int d, int mo, int y, int wd);
    wr(8, 0);
    wr(0, to_bcd(s)); wr(1, to_bcd(mi)); wr(2, to_bcd(h));
    wr(3, to_bcd(d)); wr(4, to_bcd(mo)); wr(5, to_bcd(y)); wr(6, to_bcd(wd));
    scan();
    wr(8, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cur_req = "R1";  scan();
    cur_req = "R12"; rd(7); rd(15); rd(31);
    cur_req = "R3";  ticks(5, 0); scan();
    cur_req = "R7";  set_time(58, 59, 23, 28, 2, 23, 6);
    cur_req = "R5";  ticks(3, 1); scan();
    cur_req = "R6";  scan();
    cur_req = "R5";  set_time(59, 59, 23, 28, 2, 24, 3); ticks(1, 0); scan();
    set_time(59, 59, 23, 29, 2, 24, 4); ticks(1, 0); scan();
    set_time(59, 59, 23, 28, 2, 0, 1); ticks(1, 2); scan();
    set_time(59, 59, 23, 30, 4, 10, 2); ticks(1, 0); scan();
    cur_req = "R4";  set_time(59, 59, 23, 31, 12, 99, 5); ticks(2, 0); scan();
    cur_req = "R7";  wr(0, 8'h33); wr(3, 8'h15); wr(6, 8'h02); scan();
    cur_req = "R8";  wr(8, 8'h41); ticks(30, 0); scan();
    cur_req = "R9";  wr(8, 8'h81); scan(); ticks(5, 0); scan();
    wr(8, 8'h01); scan();
    wr(8, 8'hC1); ticks(3, 0); scan();
    cur_req = "R10"; wr(9, 8'hFF); scan(); wr(8, 8'h00); scan(); wr(9, 8'h00); scan();
    cur_req = "R2";  scan();
    cur_req = "R11"; set_time(0, 58, 23, 31, 12, 99, 6); ticks(4000, 0);
    ticks(300, 2); scan();
    cur_req = "R3";  wr(8, 0); ticks(20, 0); scan();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule